// File: doc/BRIEF.md
# Prefetching Input Stream Buffer

This block sits between main memory and a streaming accelerator and keeps a short run of 64-byte bursts ready for it. A processor-side port issues burst load requests, each carrying a byte address. The request is compared with the burst at the head of the buffer. If it matches, the burst is already present or on its way, and nothing else happens. If it does not match, the whole buffer is thrown away. The block then asks memory for the missed burst first, followed by the sequential bursts after it. This prefetch run is never longer than the buffer and never runs past the end of the page that holds the missed address.

Memory is reached through a request port with a valid/ready handshake. Responses come back on a response port, strictly in request order. Each request carries a generation tag. When a newer miss has flushed the buffer, responses for the older run still carry the old tag and are dropped. The accelerator takes bursts from an output port with a valid/ready handshake, in ascending address order. Back-pressure works as follows: while `out_valid` is high and `out_ready` is low, the head burst and its address are held unchanged. On the memory side, `mreq_valid` and `mreq_addr` are held unchanged until `mreq_ready` accepts them, unless a miss replaces the run. The response port has no ready signal, so the block always accepts a response.

Top module: `psb_stream_buffer`

## Requirements
- R1: After reset, `out_valid` is 0, `empty` is 1 and `mreq_valid` is 0.
- R2: A burst address is the byte address with its low 6 bits cleared. The low 6 bits of `ld_addr` have no effect on the hit decision. Every `mreq_addr` and `out_addr` has its low 6 bits at zero.
- R3: A load whose burst differs from the head burst, or that arrives when no entry is allocated, is a miss. A miss flushes every entry. Memory requests then go out one per accepted handshake: first the missed burst, then the addresses that follow it in 64-byte steps, in ascending order. This holds even if the requested burst sits deeper in the buffer.
- R4: A load whose burst equals the head entry's burst is a hit, whether or not that entry has been filled yet. A hit issues no memory request and leaves the request tag unchanged. The hit test uses the head as it stands before any pop in the same cycle.
- R5: A run holds 1 + P entries, where P is the smaller of 15 and the number of bursts left in the page after the missed one. The page size is 4096 bytes by default.
- R6: Each response of the current generation fills the next allocated entry. An entry cannot be popped until it is filled. While the head is unfilled or absent, `out_valid` is 0 and `empty` is 1, including the cycle right after a miss.
- R7: `mreq_tag` is a 4-bit generation count that increments on every miss. A response is discarded if its tag differs from the current generation, or if it arrives in the same cycle as a miss.
- R8: Bursts leave on `out_valid && out_ready`, in ascending address order. `out_data` is the data returned for `out_addr`.
- R9: While `out_valid` is high and `out_ready` is low, and no miss occurs, `out_addr` and `out_data` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request strobe |
| ld_addr | input | 32 | Load byte address |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts request |
| mreq_addr | output | 32 | Burst-aligned request address |
| mreq_tag | output | 4 | Generation tag of the request |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_tag | input | 4 | Tag echoed with the response |
| mrsp_data | input | 512 | Burst data |
| out_valid | output | 1 | Head burst available |
| out_ready | input | 1 | Accelerator takes the head |
| out_addr | output | 32 | Address of the head burst |
| out_data | output | 512 | Head burst data |
| empty | output | 1 | No filled head exists |

## Verification
The sharpest collisions are a miss landing in the same cycle as a pop, and a miss landing in the same cycle as a response or a request handshake from the older run. A long memory latency keeps old-generation responses in flight while the second miss is issued. A random phase then mixes frequent loads with partial ready duty cycles on both handshakes, so these events coincide many times. A queue-based reference model predicts the expected outputs for every clock, and the bench compares the outputs against it each cycle. A stale fill or a pop lost to a flush shows up as a wrong address, data or valid on the next cycle.

// File: rtl/psb_pkg.sv
package psb_pkg;

  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_HIT  = 2'd1,
    LD_MISS = 2'd2
  } ld_kind_e;

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/psb_probe.sv
module psb_probe
  import psb_pkg::*;
#(
  parameter int BIW         = 26,
  parameter int PW          = 5,
  parameter int DEPTH       = 16,
  parameter int PAGE_BURSTS = 64
) (
  input  logic           ld_valid,
  input  logic [BIW-1:0] ld_burst,
  input  logic [BIW-1:0] head_burst,
  input  logic           head_present,
  output ld_kind_e       kind,
  output logic [PW-1:0]  new_len
);
  localparam int PBW = $clog2(PAGE_BURSTS);

  logic [PBW-1:0] pos_in_page;
  int unsigned    left_in_page;
  int unsigned    pf_count;

  always_comb begin
    pos_in_page  = ld_burst[PBW-1:0];
    left_in_page = 32'(PAGE_BURSTS - 1) - 32'(pos_in_page);
    pf_count     = min_u(left_in_page, 32'(DEPTH - 1));
    new_len      = PW'(pf_count + 1);
  end

  always_comb begin
    if (!ld_valid)                                 kind = LD_IDLE;
    else if (head_present && head_burst == ld_burst) kind = LD_HIT;
    else                                           kind = LD_MISS;
  end

  always_comb begin
    if (ld_valid) a_len_r5 : assert (new_len >= PW'(1) && new_len <= PW'(DEPTH));
  end

endmodule

// File: rtl/psb_ptrs.sv
module psb_ptrs
  import psb_pkg::*;
#(
  parameter int BIW   = 26,
  parameter int PW    = 5,
  parameter int GW    = 4,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ld_kind_e       kind,
  input  logic [BIW-1:0] new_base,
  input  logic [PW-1:0]  new_len,
  input  logic           pop,
  input  logic           req_fire,
  input  logic           rsp_valid,
  input  logic [GW-1:0]  rsp_tag,
  output logic [BIW-1:0] base_q,
  output logic [PW-1:0]  len_q,
  output logic [PW-1:0]  hd_q,
  output logic [PW-1:0]  rq_q,
  output logic [PW-1:0]  fl_q,
  output logic [GW-1:0]  gen_q,
  output logic           fill_en
);
  logic is_miss;

  assign is_miss = (kind == LD_MISS);
  assign fill_en = rsp_valid && !is_miss && (rsp_tag == gen_q) && (fl_q < rq_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      hd_q   <= '0;
      rq_q   <= '0;
      fl_q   <= '0;
      gen_q  <= '0;
    end else if (is_miss) begin
      base_q <= new_base;
      len_q  <= new_len;
      hd_q   <= '0;
      rq_q   <= '0;
      fl_q   <= '0;
      gen_q  <= gen_q + GW'(1);
    end else begin
      if (pop)      hd_q <= hd_q + PW'(1);
      if (req_fire) rq_q <= rq_q + PW'(1);
      if (fill_en)  fl_q <= fl_q + PW'(1);
    end
  end

  p_fill_trails_req_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (fl_q <= rq_q) && (hd_q <= fl_q));

  p_req_bound_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (rq_q <= len_q) && (len_q <= PW'(DEPTH)));

  p_gen_step_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_MISS) |=> (gen_q == GW'($past(gen_q) + GW'(1))));

  p_hit_keeps_run_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_HIT) |=> ($stable(gen_q) && $stable(base_q) && $stable(len_q)));

endmodule

// File: rtl/psb_store.sv
module psb_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 512,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && widx == PW'(g)) slot_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ridx == PW'(i)) rdata = slot_q[i];
    end
  end

endmodule

// File: rtl/psb_stream_buffer.sv
module psb_stream_buffer
  import psb_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DEPTH       = 16,
  parameter int BURST_BYTES = 64,
  parameter int PAGE_BYTES  = 4096,
  parameter int GW          = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_valid,
  input  logic [AW-1:0]            ld_addr,
  output logic                     mreq_valid,
  input  logic                     mreq_ready,
  output logic [AW-1:0]            mreq_addr,
  output logic [GW-1:0]            mreq_tag,
  input  logic                     mrsp_valid,
  input  logic [GW-1:0]            mrsp_tag,
  input  logic [BURST_BYTES*8-1:0] mrsp_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [AW-1:0]            out_addr,
  output logic [BURST_BYTES*8-1:0] out_data,
  output logic                     empty
);
  localparam int OFFW        = $clog2(BURST_BYTES);
  localparam int BIW         = AW - OFFW;
  localparam int DW          = BURST_BYTES * 8;
  localparam int PW          = $clog2(DEPTH + 1);
  localparam int PAGE_BURSTS = PAGE_BYTES / BURST_BYTES;

  logic [BIW-1:0] ld_burst;
  logic           unused_low_bits;
  logic [BIW-1:0] base_q, head_burst, req_burst;
  logic [PW-1:0]  len_q, hd_q, rq_q, fl_q, new_len;
  logic [GW-1:0]  gen_q;
  logic           fill_en, pop, req_fire, head_present;
  ld_kind_e       kind;

  assign ld_burst        = ld_addr[AW-1:OFFW];
  assign unused_low_bits = ^ld_addr[OFFW-1:0];

  assign head_present = (hd_q < len_q);
  assign head_burst   = base_q + BIW'(hd_q);
  assign req_burst    = base_q + BIW'(rq_q);

  psb_probe #(
    .BIW(BIW), .PW(PW), .DEPTH(DEPTH), .PAGE_BURSTS(PAGE_BURSTS)
  ) probe_i (
    .ld_valid    (ld_valid),
    .ld_burst    (ld_burst),
    .head_burst  (head_burst),
    .head_present(head_present),
    .kind        (kind),
    .new_len     (new_len)
  );

  psb_ptrs #(
    .BIW(BIW), .PW(PW), .GW(GW), .DEPTH(DEPTH)
  ) ptrs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .new_base (ld_burst),
    .new_len  (new_len),
    .pop      (pop),
    .req_fire (req_fire),
    .rsp_valid(mrsp_valid),
    .rsp_tag  (mrsp_tag),
    .base_q   (base_q),
    .len_q    (len_q),
    .hd_q     (hd_q),
    .rq_q     (rq_q),
    .fl_q     (fl_q),
    .gen_q    (gen_q),
    .fill_en  (fill_en)
  );

  psb_store #(
    .DEPTH(DEPTH), .DW(DW), .PW(PW)
  ) store_i (
    .clk  (clk),
    .we   (fill_en),
    .widx (fl_q),
    .wdata(mrsp_data),
    .ridx (hd_q),
    .rdata(out_data)
  );

  assign mreq_valid = (rq_q < len_q);
  assign mreq_addr  = {req_burst, {OFFW{1'b0}}};
  assign mreq_tag   = gen_q;
  assign req_fire   = mreq_valid && mreq_ready;

  assign out_valid  = (hd_q < fl_q);
  assign out_addr   = {head_burst, {OFFW{1'b0}}};
  assign empty      = !out_valid;
  assign pop        = out_valid && out_ready;

  p_req_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready && kind != LD_MISS) |=> (mreq_valid && $stable(mreq_addr)));

  p_pop_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && kind != LD_MISS) |=> (out_valid && $stable(out_addr)));

  p_miss_clears_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_MISS) |=> (!out_valid && mreq_valid));

  p_req_seq_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && kind != LD_MISS && rq_q + PW'(1) < len_q) |=>
      (mreq_addr == $past(mreq_addr) + AW'(BURST_BYTES)));

endmodule

// File: tb/psb_stream_buffer_tb_top.sv
`timescale 1ns/1ps
module psb_stream_buffer_tb_top;
  localparam int GW = 4;
  localparam int DW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic [31:0]   ld_addr = '0;
  logic          mreq_valid, mreq_ready = 1'b0;
  logic [31:0]   mreq_addr;
  logic [GW-1:0] mreq_tag;
  logic          mrsp_valid = 1'b0;
  logic [GW-1:0] mrsp_tag = '0;
  logic [DW-1:0] mrsp_data = '0;
  logic          out_valid, out_ready = 1'b0;
  logic [31:0]   out_addr;
  logic [DW-1:0] out_data;
  logic          empty;

  always #10 clk = ~clk;

  psb_stream_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mreq_tag(mreq_tag), .mrsp_valid(mrsp_valid), .mrsp_tag(mrsp_tag),
    .mrsp_data(mrsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_data(out_data), .empty(empty)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { int unsigned b; bit f; } ent_t;
  typedef struct { logic [31:0] a; logic [GW-1:0] t; int due; } mq_t;

  ent_t        ent[$];
  int unsigned preq[$];
  int unsigned gen = 0;
  mq_t         mq[$];
  logic [31:0] pops[$];
  int          req_count = 0;
  int          cyc = 0;
  int          mem_lat = 3;
  int          mem_pct = 100;
  int          out_pct = 100;

  function automatic logic [DW-1:0] pat(input logic [31:0] a);
    logic [DW-1:0] d;
    for (int w = 0; w < DW / 32; w++) d[w*32 +: 32] = a ^ (32'(w) * 32'h9E3779B9);
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit eov;
    eov = (ent.size() > 0) && ent[0].f;
    chk(out_valid == eov, "R6", "out_valid", 64'(out_valid), 64'(eov));
    chk(empty == !eov, "R6", "empty", 64'(empty), 64'(!eov));
    if (eov && out_valid) begin
      chk(out_addr == 32'(ent[0].b << 6), "R8", "out_addr", 64'(out_addr), 64'(ent[0].b << 6));
      chk(out_data == pat(32'(ent[0].b << 6)), "R7", "out_data", out_data[63:0],
          pat(32'(ent[0].b << 6)) >> 0);
    end
    chk(mreq_valid == (preq.size() > 0), "R3", "mreq_valid", 64'(mreq_valid), 64'(preq.size() > 0));
    if (preq.size() > 0 && mreq_valid) begin
      chk(mreq_addr == 32'(preq[0] << 6), "R3", "mreq_addr", 64'(mreq_addr), 64'(preq[0] << 6));
      chk(mreq_tag == GW'(gen), "R7", "mreq_tag", 64'(mreq_tag), 64'(GW'(gen)));
    end
  endtask

  task automatic tick(input bit ldv, input logic [31:0] lda);
    bit mr, orr, rv, hit, miss, eov;
    logic [GW-1:0] rt;
    int unsigned b, left, pf;
    @(negedge clk);
    cyc++;
    compare();
    mr  = ($urandom_range(99) < mem_pct);
    orr = ($urandom_range(99) < out_pct);
    rv = 1'b0; rt = '0;
    mrsp_data = '0;
    if (mq.size() > 0 && mq[0].due <= cyc) begin
      rv = 1'b1; rt = mq[0].t; mrsp_data = pat(mq[0].a);
      void'(mq.pop_front());
    end
    ld_valid = ldv; ld_addr = lda; mreq_ready = mr; out_ready = orr;
    mrsp_valid = rv; mrsp_tag = rt;
    if (mreq_valid && mr) begin
      mq.push_back('{a: mreq_addr, t: mreq_tag, due: cyc + mem_lat});
      req_count++;
    end
    if (out_valid && orr) pops.push_back(out_addr);
    // reference model step
    eov  = (ent.size() > 0) && ent[0].f;
    hit  = ldv && (ent.size() > 0) && (ent[0].b == (lda >> 6));
    miss = ldv && !hit;
    if (eov && orr) void'(ent.pop_front());
    if (preq.size() > 0 && mr) void'(preq.pop_front());
    if (miss) begin
      ent.delete(); preq.delete();
      b = lda >> 6;
      left = 63 - (b % 64);
      pf = (left < 15) ? left : 15;
      for (int k = 0; k <= int'(pf); k++) begin
        ent.push_back('{b: b + k, f: 1'b0});
        preq.push_back(b + k);
      end
      gen++;
    end else if (rv && rt == GW'(gen)) begin
      for (int k = 0; k < ent.size(); k++) begin
        if (!ent[k].f) begin ent[k].f = 1'b1; break; end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 32'h0);
  endtask

  task automatic check_order(input string req);
    for (int i = 1; i < pops.size(); i++)
      chk(pops[i] == pops[i-1] + 32'd64, req, "pop order", 64'(pops[i]), 64'(pops[i-1] + 32'd64));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rc;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 0);
    chk(empty == 1'b1, "R1", "empty after reset", 64'(empty), 1);
    chk(mreq_valid == 1'b0, "R1", "mreq_valid after reset", 64'(mreq_valid), 0);

    // R3 / R5: full run from page start, held by back-pressure
    out_pct = 0; req_count = 0;
    tick(1'b1, 32'h1000);
    idle(40);
    chk(req_count == 16, "R5", "run length at page start", 64'(req_count), 16);
    held = out_addr;
    idle(5);
    chk(out_valid && out_addr == held, "R9", "head held under back-pressure", 64'(out_addr), 64'(held));
    chk(pops.size() == 0, "R9", "no pop without ready", 64'(pops.size()), 0);
    out_pct = 100; idle(30);
    chk(pops.size() == 16, "R8", "all bursts popped", 64'(pops.size()), 16);
    check_order("R8");

    // R2 / R4: hits do not touch memory; deeper entry still misses
    pops.delete(); out_pct = 0;
    tick(1'b1, 32'h2000); idle(30);
    rc = req_count;
    tick(1'b1, 32'h203F); idle(5);
    chk(req_count == rc, "R2", "low address bits ignored", 64'(req_count), 64'(rc));
    tick(1'b1, 32'h2000); idle(5);
    chk(req_count == rc, "R4", "hit issues no request", 64'(req_count), 64'(rc));
    tick(1'b1, 32'h2040); idle(30);
    chk(req_count == rc + 16, "R3", "non-head burst misses", 64'(req_count), 64'(rc + 16));

    // R5: page end clipping
    rc = req_count;
    tick(1'b1, 32'h1F80); idle(20);
    chk(req_count == rc + 2, "R5", "two bursts left in page", 64'(req_count), 64'(rc + 2));
    rc = req_count;
    tick(1'b1, 32'h1FC0); idle(20);
    chk(req_count == rc + 1, "R5", "last burst of page", 64'(req_count), 64'(rc + 1));

    // R6: head unfilled right after a miss
    mem_lat = 8; out_pct = 100;
    tick(1'b1, 32'h3000); tick(1'b0, 32'h0);
    chk(empty == 1'b1, "R6", "empty while head pending", 64'(empty), 1);
    chk(out_valid == 1'b0, "R6", "out_valid while head pending", 64'(out_valid), 0);
    idle(40);

    // R7: stale responses of a flushed run are dropped
    pops.delete(); mem_lat = 20;
    tick(1'b1, 32'h4000); idle(5);
    tick(1'b1, 32'h5000); idle(70);
    chk(pops.size() == 16, "R7", "only new run popped", 64'(pops.size()), 16);
    if (pops.size() > 0)
      chk(pops[0] == 32'h5000, "R7", "first pop of new run", 64'(pops[0]), 64'h5000);
    check_order("R7");

    // random phase: misses, hits, pops and responses collide
    mem_lat = 4; mem_pct = 70; out_pct = 60;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(19) == 0) begin
        if ($urandom_range(1) == 0 && ent.size() > 0)
          tick(1'b1, 32'(ent[0].b << 6) | 32'($urandom_range(63)));
        else
          tick(1'b1, 32'($urandom_range(3)) << 12 | 32'($urandom_range(63)) << 6);
      end else begin
        tick(1'b0, 32'h0);
      end
    end
    mem_pct = 100; out_pct = 100; idle(60);
    chk(empty == 1'b1 && mreq_valid == 1'b0, "R8", "drained after random phase",
        64'({empty, mreq_valid}), 64'h2);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule